// File: doc/BRIEF.md
# PDM Microphone Output Interface

This block is the digital output stage of a pulse-density-modulated microphone that can share one clock wire and one data wire with a second microphone. A host drives the microphone clock. Each microphone owns one half of every clock period on the data wire. A strap input chooses the half. In its own half the block drives the current modulator bit. In the other half it releases the wire so the partner can drive.

Everything runs on a fast, free-running reference clock. The microphone clock is synchronised into that domain. Its rising and falling edges are found from the synchronised samples. A counter of reference cycles since the last edge detects a stopped or very slow microphone clock, and the block then sleeps. A timed blanking period follows every wake-up. Both the power-good input and sleep keep the output released. The tri-state buffer is external: `pdm_oe` enables it and `pdm_data` is the value it drives.

Top module: `pdm_mic_tx`

## Requirements
- R1: With `chan_sel` = 0, a falling microphone-clock edge launches the slot and the following rising edge releases it. `pdm_oe` is high only between these two points.
- R2: With `chan_sel` = 1, the roles of the edges swap. A rising edge launches the slot and the following falling edge releases it.
- R3: Let E be the first reference edge that samples a new `mic_clk` level. `pdm_oe` asserts at reference edge E+3+ON_DLY after a launching level change. It deasserts at edge E+3+OFF_DLY after a releasing level change.
- R4: `pdm_data` equals the `mod_bit` value sampled at reference edge E+2 of the launching change, and holds that value while `pdm_oe` is high. `pdm_data` is 0 whenever `pdm_oe` is 0.
- R5: When SLEEP_CYCLES reference cycles pass with no detected clock edge, the block enters sleep and keeps `pdm_oe` low.
- R6: The first detected edge in sleep starts a blanking period of WAKE_CYCLES reference cycles. Drive can resume only after that period, and only if clock activity continues through it.
- R7: While `pwr_good` is 0, `pdm_oe` is 0 in the same cycle and the block returns to sleep. When power returns, a full wake-up blanking period is required again.
- R8: During and right after reset, the block is asleep, with `pdm_oe` = 0 and `pdm_data` = 0.
- R9: A microphone clock whose half period exceeds SLEEP_CYCLES reference cycles never enables the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mic_clk | input | 1 | Externally supplied microphone clock, asynchronous |
| chan_sel | input | 1 | Strap: 0 launches on falling edge, 1 launches on rising edge |
| pwr_good | input | 1 | Supply good; 0 forces release and sleep |
| mod_bit | input | 1 | Modulator bitstream input |
| pdm_data | output | 1 | Value for the shared data wire |
| pdm_oe | output | 1 | Tri-state enable for the shared data wire |

## Verification
Assertions check several rules on every cycle. Sleep may never jump straight to driving. An idle count at the limit or a power loss forces the next state out of the live mode. A detected launching edge always arms the turn-on. The driven bit never changes while the driver's enable is held. Other behaviour only shows up in the bench's scenarios, which run against a cycle-level reference model. These cover the exact turn-on and turn-off cycle counts for both strap settings, the blanking length after wake-up and after power returns, the entry into sleep when the clock stops, and the fact that a clock which is too slow never brings the block to drive.

// File: rtl/pdm_mic_pkg.sv
package pdm_mic_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_WAKE  = 2'd1,
        MODE_LIVE  = 2'd2
    } mic_mode_e;

    // Bits needed to hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pdm_clk_sense.sv
module pdm_clk_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mic_clk,
    output logic rise_p,
    output logic fall_p
);
    // Chain: SYNC_STAGES synchroniser flops plus one history flop.
    localparam int CHAIN = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0] sh;
    } sense_t;

    sense_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.sh = {cur_q.sh[CHAIN-2:0], mic_clk};
        rise_p   =  cur_q.sh[CHAIN-2] & ~cur_q.sh[CHAIN-1];
        fall_p   = ~cur_q.sh[CHAIN-2] &  cur_q.sh[CHAIN-1];
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/pdm_activity_mon.sv
module pdm_activity_mon
    import pdm_mic_pkg::*;
#(
    parameter int SLEEP_CYCLES = 100000,
    parameter int WAKE_CYCLES  = 1000000
) (
    input  logic      ref_clk,
    input  logic      rst_n,
    input  logic      edge_p,
    input  logic      pwr_good,
    output mic_mode_e mode
);
    localparam int IW = cnt_w(SLEEP_CYCLES);
    localparam int WW = cnt_w(WAKE_CYCLES);
    localparam logic [IW-1:0] IDLE_LIM = IW'(SLEEP_CYCLES);
    localparam logic [WW-1:0] WAKE_END = WW'(WAKE_CYCLES - 1);

    typedef struct packed {
        mic_mode_e     mode;
        logic [IW-1:0] idle;
        logic [WW-1:0] wake;
    } act_t;

    act_t cur_q, nxt_d;
    logic stalled;

    always_comb begin
        nxt_d   = cur_q;
        stalled = (cur_q.idle >= IDLE_LIM);

        // Cycles since the last edge, saturating at the limit
        if (edge_p)         nxt_d.idle = '0;
        else if (!stalled)  nxt_d.idle = cur_q.idle + IW'(1);

        if (!pwr_good) begin
            nxt_d.mode = MODE_SLEEP;
            nxt_d.wake = '0;
        end else begin
            unique case (cur_q.mode)
                MODE_SLEEP: begin
                    if (edge_p) begin
                        nxt_d.mode = MODE_WAKE;
                        nxt_d.wake = '0;
                    end
                end
                MODE_WAKE: begin
                    if (stalled)                     nxt_d.mode = MODE_SLEEP;
                    else if (cur_q.wake == WAKE_END) nxt_d.mode = MODE_LIVE;
                    else                             nxt_d.wake = cur_q.wake + WW'(1);
                end
                MODE_LIVE: begin
                    if (stalled) nxt_d.mode = MODE_SLEEP;
                end
                default: nxt_d.mode = MODE_SLEEP;
            endcase
        end
        mode = cur_q.mode;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode <= MODE_SLEEP;
            cur_q.idle <= IDLE_LIM;
            cur_q.wake <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assert_no_direct_live_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cur_q.mode == MODE_SLEEP |=> cur_q.mode != MODE_LIVE);

    assert_idle_blocks_live_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cur_q.idle >= IDLE_LIM |=> cur_q.mode != MODE_LIVE);

    assert_power_loss_sleeps_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pwr_good |=> cur_q.mode == MODE_SLEEP);

endmodule

// File: rtl/pdm_phase_driver.sv
module pdm_phase_driver
    import pdm_mic_pkg::*;
#(
    parameter int ON_DLY  = 0,
    parameter int OFF_DLY = 0
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic launch_p,
    input  logic release_p,
    input  logic mod_bit,
    output logic drv_oe,
    output logic drv_bit
);
    localparam int NW = cnt_w(ON_DLY);
    localparam int FW = cnt_w(OFF_DLY);

    typedef struct packed {
        logic          oe;
        logic          bit_v;
        logic          pend_on;
        logic          pend_off;
        logic [NW-1:0] on_cnt;
        logic [FW-1:0] off_cnt;
    } drv_t;

    drv_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;

        if (cur_q.pend_on) begin
            if (cur_q.on_cnt == '0) begin
                nxt_d.oe      = 1'b1;
                nxt_d.pend_on = 1'b0;
            end else begin
                nxt_d.on_cnt = cur_q.on_cnt - NW'(1);
            end
        end

        if (cur_q.pend_off) begin
            if (cur_q.off_cnt == '0) begin
                nxt_d.oe       = 1'b0;
                nxt_d.pend_off = 1'b0;
            end else begin
                nxt_d.off_cnt = cur_q.off_cnt - FW'(1);
            end
        end

        if (launch_p) begin
            nxt_d.pend_on = 1'b1;
            nxt_d.on_cnt  = NW'(ON_DLY);
            nxt_d.bit_v   = mod_bit;
        end
        if (release_p) begin
            nxt_d.pend_off = 1'b1;
            nxt_d.off_cnt  = FW'(OFF_DLY);
        end

        drv_oe  = cur_q.oe;
        drv_bit = cur_q.bit_v;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assert_launch_arms_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        launch_p |=> cur_q.pend_on);

    assert_bit_held_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cur_q.oe && $past(cur_q.oe) |-> $stable(cur_q.bit_v));

endmodule

// File: rtl/pdm_mic_tx.sv
module pdm_mic_tx
    import pdm_mic_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int SLEEP_CYCLES = 100000,
    parameter int WAKE_CYCLES  = 1000000,
    parameter int ON_DLY       = 0,
    parameter int OFF_DLY      = 0
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mic_clk,
    input  logic chan_sel,
    input  logic pwr_good,
    input  logic mod_bit,
    output logic pdm_data,
    output logic pdm_oe
);
    logic      rise_p, fall_p;
    logic      launch_p, release_p;
    logic      drv_oe, drv_bit;
    mic_mode_e mode;

    pdm_clk_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .mic_clk (mic_clk),
        .rise_p  (rise_p),
        .fall_p  (fall_p)
    );

    pdm_activity_mon #(
        .SLEEP_CYCLES (SLEEP_CYCLES),
        .WAKE_CYCLES  (WAKE_CYCLES)
    ) u_act (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .edge_p   (rise_p | fall_p),
        .pwr_good (pwr_good),
        .mode     (mode)
    );

    // Strap picks which edge opens the slot
    always_comb begin
        launch_p  = chan_sel ? rise_p : fall_p;
        release_p = chan_sel ? fall_p : rise_p;
    end

    pdm_phase_driver #(
        .ON_DLY  (ON_DLY),
        .OFF_DLY (OFF_DLY)
    ) u_drv (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .launch_p  (launch_p),
        .release_p (release_p),
        .mod_bit   (mod_bit),
        .drv_oe    (drv_oe),
        .drv_bit   (drv_bit)
    );

    always_comb begin
        pdm_oe   = drv_oe & (mode == MODE_LIVE) & pwr_good;
        pdm_data = pdm_oe & drv_bit;
    end

endmodule

// File: tb/pdm_mic_tx_bench.sv
module pdm_mic_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SLEEP_C = 40;
    localparam int WAKE_C  = 60;
    localparam int ON_D    = 1;
    localparam int OFF_D   = 2;

    logic ref_clk = 1'b0;
    logic rst_n = 1'b0, mic_clk = 1'b0, chan_sel = 1'b0, pwr_good = 1'b0, mod_bit = 1'b0;
    logic pdm_data, pdm_oe;

    pdm_mic_tx #(
        .SYNC_STAGES(2), .SLEEP_CYCLES(SLEEP_C), .WAKE_CYCLES(WAKE_C),
        .ON_DLY(ON_D), .OFF_DLY(OFF_D)
    ) u_pdm_mic_tx (
        .ref_clk(ref_clk), .rst_n(rst_n), .mic_clk(mic_clk), .chan_sel(chan_sel),
        .pwr_good(pwr_good), .mod_bit(mod_bit), .pdm_data(pdm_data), .pdm_oe(pdm_oe)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    int    n_checks = 0, n_errs = 0, hi_cnt = 0;
    string req_tag = "R8";
    bit    done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: built from the requirements on sampled stimulus
    bit     h0, h1, h2, m_drv, m_dat;
    int     m_idle, m_wake, m_mode; // 0 sleep, 1 wake, 2 live
    longint n, on_at, off_at;

    always @(posedge ref_clk) begin
        bit evt, rz, fl, stall, launch, rel, e_oe, e_dat;
        #1;
        if (!rst_n) begin
            h0 = 0; h1 = 0; h2 = 0; m_drv = 0; m_dat = 0;
            m_idle = SLEEP_C; m_wake = 0; m_mode = 0;
            n = 0; on_at = -1; off_at = -1;
        end else begin
            rz = h1 & ~h2; fl = ~h1 & h2; evt = rz | fl;
            stall = (m_idle >= SLEEP_C);
            if (evt) m_idle = 0; else if (!stall) m_idle++;
            if (!pwr_good) begin m_mode = 0; m_wake = 0; end
            else if (m_mode == 0) begin if (evt) begin m_mode = 1; m_wake = 0; end end
            else if (m_mode == 1) begin
                if (stall) m_mode = 0;
                else if (m_wake == WAKE_C - 1) m_mode = 2;
                else m_wake++;
            end else if (stall) m_mode = 0;
            if (n == on_at)  m_drv = 1;
            if (n == off_at) m_drv = 0;
            launch = chan_sel ? rz : fl;
            rel    = chan_sel ? fl : rz;
            if (launch) begin on_at = n + 1 + ON_D; m_dat = mod_bit; end
            if (rel) off_at = n + 1 + OFF_D;
            h2 = h1; h1 = h0; h0 = mic_clk;
            n++;
        end
        e_oe  = m_drv && (m_mode == 2) && pwr_good;
        e_dat = e_oe && m_dat;
        chk(pdm_oe === e_oe, req_tag, "pdm_oe", int'(pdm_oe), int'(e_oe));
        chk(pdm_data === e_dat, "R4", "pdm_data", int'(pdm_data), int'(e_dat));
        if (pdm_oe === 1'b1) hi_cnt++;
    end

    // Microphone clock and bitstream generator
    int mic_half = 0;
    initial begin
        int cnt = 0;
        int pat = 7;
        forever begin
            @(negedge ref_clk);
            if (mic_half > 0) begin
                cnt++;
                if (cnt >= mic_half) begin
                    cnt = 0;
                    mic_clk = ~mic_clk;
                    pat = pat * 5 + 3;
                    mod_bit = pat[3];
                end
            end else cnt = 0;
        end
    end

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge ref_clk);
    endtask

    task automatic do_reset(input bit sel);
        mic_half = 0;
        wait_cyc(1);
        rst_n = 0; mic_clk = 0; chan_sel = sel; pwr_good = 0;
        wait_cyc(4);
        rst_n = 1;
    endtask

    initial begin
        do_reset(1'b0);
        req_tag = "R8";
        wait_cyc(3);
        chk(pdm_oe === 1'b0, "R8", "oe after reset", int'(pdm_oe), 0);

        // Right channel: wake blanking, then driving on the low half
        pwr_good = 1; req_tag = "R1 R3 R6"; hi_cnt = 0; mic_half = 8;
        wait_cyc(480);
        chk(hi_cnt > 0, "R1", "right slot drove", hi_cnt, 1);

        // Stop the clock: sleep
        req_tag = "R5"; mic_half = 0;
        wait_cyc(80);
        chk(pdm_oe === 1'b0, "R5", "oe in sleep", int'(pdm_oe), 0);

        // Restart: blanking must hold
        req_tag = "R6"; hi_cnt = 0; mic_half = 8;
        wait_cyc(48);
        chk(hi_cnt == 0, "R6", "blanked after wake", hi_cnt, 0);
        wait_cyc(200);
        chk(hi_cnt > 0, "R6", "drives after blanking", hi_cnt, 1);

        // Power loss while driving
        req_tag = "R7";
        do @(negedge ref_clk); while (pdm_oe !== 1'b1);
        pwr_good = 0;
        #1;
        chk(pdm_oe === 1'b0, "R7", "oe on power loss", int'(pdm_oe), 0);
        wait_cyc(20);
        pwr_good = 1; hi_cnt = 0;
        wait_cyc(45);
        chk(hi_cnt == 0, "R7", "blanked after power return", hi_cnt, 0);
        wait_cyc(150);
        chk(hi_cnt > 0, "R7", "drives after power return", hi_cnt, 1);

        // Left channel
        do_reset(1'b1);
        pwr_good = 1; req_tag = "R2 R3"; hi_cnt = 0; mic_half = 8;
        wait_cyc(480);
        chk(hi_cnt > 0, "R2", "left slot drove", hi_cnt, 1);

        // Too-slow clock never enables
        req_tag = "R9"; mic_half = 50;
        wait_cyc(120);
        hi_cnt = 0;
        wait_cyc(500);
        chk(hi_cnt == 0, "R9", "slow clock silent", hi_cnt, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge ref_clk);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule